// File: doc/BRIEF.md
# Boot Shadow-Copy Memory Decoder

This block is the address glue for a processor with a 24-bit address bus whose bank byte is multiplexed onto the data lines while the phase-2 clock is low. It captures that bank byte and decodes each bus cycle to one of three targets: general RAM, a slow non-volatile program store, or a page of external I/O registers. A cycle that reaches the program store is stretched by pulling the ready line low for a fixed number of phase-2 cycles, because the store answers too slowly for a single full-speed cycle.

Out of reset the block runs in a shadow mode. In this mode the program store appears in the upper half of bank 0 and cannot be written there. Reads in that range come from the store, and writes in that range go to the RAM beneath it. Boot code copies the store into RAM with a simple read-then-write-back loop. It then writes to an internal control register. That write ends the shadow mode. The store moves back to the upper half of the top bank, where it can be written, and bank 0 runs from RAM with no wait states.

Top module: `boot_shadow_decoder`

## Requirements
- R1: After reset the shadow mode is on. While reset is held, no chip select, write enable or output enable is asserted (all are active low).
- R2: The bank byte is taken from `data_in` at the rising edge of `phi2` and is used for decode for the whole high phase, whatever `data_in` does during that phase.
- R3: With the shadow mode off, any access to bank 0xFF addresses 0x8000 to 0xFFFF selects the store (`store_cs_n` low), and a write there asserts `we_n`.
- R4: With the shadow mode on, a read of bank 0x00 addresses 0x8000 to 0xFFFF selects the store and asserts `oe_n`.
- R5: With the shadow mode on, a write to bank 0x00 addresses 0x8000 to 0xFFFF selects RAM and never the store.
- R6: Each store access holds `rdy` low for exactly WAIT_CYCLES consecutive `phi2` cycles (default 1) and then releases it. Other accesses never pull `rdy` low.
- R7: The control register sits at bank 0x00 address 0x7F00. A write to it ends the shadow mode and cannot turn it back on. No chip select is asserted for it. Other addresses 0x7F01 to 0x7FFF in bank 0 select I/O (`io_cs_n` low).
- R8: A read of the control register drives `data_oe` high and `data_out` equal to the shadow flag in bit 7, with zeros in bits 6 to 0.
- R9: With the shadow mode off, bank 0x00 addresses 0x8000 to 0xFFFF select RAM with no wait state.
- R10: With the shadow mode on, bank 0xFF addresses 0x8000 to 0xFFFF select RAM. All addresses that are not store, I/O or control select RAM in both modes.
- R11: At most one of the three chip selects is low at any time, and none is low while `phi2` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Phase-2 bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Low 16 address bits |
| data_in | input | 8 | Data bus: bank byte while phi2 is low, write data while high |
| rw | input | 1 | 1 = read, 0 = write |
| data_out | output | 8 | Control register read data |
| data_oe | output | 1 | High while data_out drives a control register read |
| ram_cs_n | output | 1 | RAM chip select, active low |
| store_cs_n | output | 1 | Program store chip select, active low |
| io_cs_n | output | 1 | External I/O page select, active low |
| oe_n | output | 1 | Read strobe to the selected device, active low |
| we_n | output | 1 | Write strobe to the selected device, active low |
| rdy | output | 1 | Ready to the processor, low to stretch a cycle |

## Verification
The assertions check the following on every phase-2 cycle: that the selects are mutually exclusive, that a shadow-mode write to the low-bank overlay goes to RAM, that the ready line drops only for a store cycle and that the wait counter advances while it is low, that the exit is permanent, and that a control-register read selects no device. Only the bench scenarios can show the end-to-end reset, copy and exit sequence. Those scenarios confirm that the RAM model holds the copied bytes, that the store model is left untouched by overlay writes, and that the same bank-0 read loses its wait state after the exit. They also show that a changing data bus during the high phase does not disturb the latched bank.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    typedef enum logic [1:0] {
        DEV_NONE  = 2'd0,
        DEV_RAM   = 2'd1,
        DEV_STORE = 2'd2,
        DEV_IO    = 2'd3
    } dev_e;

    typedef struct packed {
        logic shadow;
    } mode_state_t;
endpackage

// File: rtl/bsd_bank_latch.sv
module bsd_bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              phi2,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] data_in,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] bank_d, bank_q;

    // Low phase carries the bank byte; capture it as phi2 rises.
    always_comb begin
        bank_d = data_in;
    end

    always_ff @(posedge phi2 or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank = bank_q;
endmodule

// File: rtl/bsd_decode.sv
module bsd_decode
    import bsd_pkg::*;
#(
    parameter logic [7:0] STORE_BANK = 8'hFF,
    parameter logic [7:0] IO_PAGE    = 8'h7F,
    parameter logic [7:0] CTRL_OFS   = 8'h00
) (
    input  logic        phi2,
    input  logic        rst_n,
    input  logic [7:0]  bank,
    input  logic [15:0] addr,
    input  logic        rw,
    input  logic        shadow,
    output dev_e        dev,
    output logic        ctrl_hit
);
    logic upper_half, bank_zero, io_page, home_hit, overlay_hit;

    always_comb begin
        upper_half  = addr[15];
        bank_zero   = (bank == 8'h00);
        io_page     = bank_zero && (addr[15:8] == IO_PAGE);
        ctrl_hit    = io_page && (addr[7:0] == CTRL_OFS);
        home_hit    = (bank == STORE_BANK) && upper_half;
        overlay_hit = bank_zero && upper_half;

        if (io_page)
            dev = ctrl_hit ? DEV_NONE : DEV_IO;
        else if (shadow && overlay_hit)
            dev = rw ? DEV_STORE : DEV_RAM;   // reads from store, writes fall through
        else if (!shadow && home_hit)
            dev = DEV_STORE;
        else
            dev = DEV_RAM;
    end

    // Shadow-mode writes to the bank-0 overlay must land in RAM.
    assert_overlay_write_ram_R5: assert property (@(negedge phi2) disable iff (!rst_n)
        (shadow && bank == 8'h00 && addr[15] && !rw) |-> (dev == DEV_RAM));
endmodule

// File: rtl/bsd_wait_gen.sv
module bsd_wait_gen #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic phi2,
    input  logic rst_n,
    input  logic store_hit,
    output logic rdy
);
    localparam int WAIT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);

    generate
        if (WAIT_CYCLES == 0) begin : g_no_wait
            assign rdy = 1'b1;
        end else begin : g_wait
            localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES);

            typedef struct packed {
                logic [WAIT_W-1:0] cnt;
            } wait_state_t;

            wait_state_t st_d, st_q;
            logic        stretch;

            always_comb begin
                stretch = store_hit && (st_q.cnt != WAIT_LAST);
                st_d    = st_q;
                if (stretch) st_d.cnt = st_q.cnt + 1'b1;
                else         st_d.cnt = '0;
            end

            // The counter advances at the end of each phi2 high phase.
            always_ff @(negedge phi2 or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign rdy = !(phi2 && stretch);

            assert_wait_bounded_R6: assert property (@(negedge phi2) disable iff (!rst_n)
                st_q.cnt <= WAIT_LAST);
            assert_wait_advances_R6: assert property (@(negedge phi2) disable iff (!rst_n)
                (store_hit && !rdy) |=> (st_q.cnt != '0));
        end
    endgenerate
endmodule

// File: rtl/boot_shadow_decoder.sv
module boot_shadow_decoder
    import bsd_pkg::*;
#(
    parameter logic [7:0] STORE_BANK  = 8'hFF,
    parameter logic [7:0] IO_PAGE     = 8'h7F,
    parameter logic [7:0] CTRL_OFS    = 8'h00,
    parameter int         WAIT_CYCLES = 1
) (
    input  logic        phi2,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  data_in,
    input  logic        rw,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic        ram_cs_n,
    output logic        store_cs_n,
    output logic        io_cs_n,
    output logic        oe_n,
    output logic        we_n,
    output logic        rdy
);
    logic [7:0]  bank;
    dev_e        dev;
    logic        ctrl_hit;
    logic        active;
    logic        ext_hit;
    mode_state_t mode_d, mode_q;

    bsd_bank_latch #(.BANK_W(8)) u_bank (
        .phi2    (phi2),
        .rst_n   (rst_n),
        .data_in (data_in),
        .bank    (bank)
    );

    bsd_decode #(
        .STORE_BANK (STORE_BANK),
        .IO_PAGE    (IO_PAGE),
        .CTRL_OFS   (CTRL_OFS)
    ) u_decode (
        .phi2     (phi2),
        .rst_n    (rst_n),
        .bank     (bank),
        .addr     (addr),
        .rw       (rw),
        .shadow   (mode_q.shadow),
        .dev      (dev),
        .ctrl_hit (ctrl_hit)
    );

    bsd_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .phi2      (phi2),
        .rst_n     (rst_n),
        .store_hit (dev == DEV_STORE),
        .rdy       (rdy)
    );

    // Shadow flag: set by reset, cleared by any write to the control register.
    always_comb begin
        mode_d = mode_q;
        if (ctrl_hit && !rw) mode_d.shadow = 1'b0;
    end

    always_ff @(negedge phi2 or negedge rst_n) begin
        if (!rst_n) mode_q <= '{shadow: 1'b1};
        else        mode_q <= mode_d;
    end

    always_comb begin
        active     = phi2 && rst_n;
        ext_hit    = (dev != DEV_NONE);
        ram_cs_n   = !(active && dev == DEV_RAM);
        store_cs_n = !(active && dev == DEV_STORE);
        io_cs_n    = !(active && dev == DEV_IO);
        oe_n       = !(active && rw && ext_hit);
        we_n       = !(active && !rw && ext_hit);
        data_oe    = active && rw && ctrl_hit;
        data_out   = data_oe ? {mode_q.shadow, 7'b0} : 8'h00;
    end

    assert_single_select_R11: assert property (@(negedge phi2) disable iff (!rst_n)
        $onehot0({!ram_cs_n, !store_cs_n, !io_cs_n}));
    assert_rdy_only_store_R6: assert property (@(negedge phi2) disable iff (!rst_n)
        !rdy |-> !store_cs_n);
    assert_exit_sticky_R7: assert property (@(negedge phi2) disable iff (!rst_n)
        !mode_q.shadow |=> !mode_q.shadow);
    assert_ctrl_read_no_cs_R8: assert property (@(negedge phi2) disable iff (!rst_n)
        data_oe |-> (ram_cs_n && store_cs_n && io_cs_n));
endmodule

// File: tb/boot_shadow_decoder_test.sv
`timescale 1ns/100ps
module boot_shadow_decoder_test;
    localparam int CLK_PERIOD = 126;
    localparam int EXP_WAIT   = 1;
    localparam int WATCHDOG   = 60000;

    // device codes used by the bench
    localparam int D_NONE = 0, D_RAM = 1, D_STORE = 2, D_IO = 3, D_MULTI = 4;

    logic        phi2 = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        rw = 1'b1;
    logic [7:0]  data_out;
    logic        data_oe, ram_cs_n, store_cs_n, io_cs_n, oe_n, we_n, rdy;

    int checks = 0, failures = 0, cyc = 0, low_phase_bad = 0;
    bit model_shadow = 1'b1;
    logic [7:0] ram_m   [int];
    logic [7:0] store_m [int];

    boot_shadow_decoder uut (
        .phi2(phi2), .rst_n(rst_n), .addr(addr), .data_in(data_in), .rw(rw),
        .data_out(data_out), .data_oe(data_oe), .ram_cs_n(ram_cs_n),
        .store_cs_n(store_cs_n), .io_cs_n(io_cs_n), .oe_n(oe_n), .we_n(we_n), .rdy(rdy)
    );

    always #(CLK_PERIOD/2) phi2 = ~phi2;

    always @(posedge phi2) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string req, bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] store_rd(int off);
        if (store_m.exists(off)) return store_m[off];
        return 8'((off * 7) ^ (off >> 8) ^ 8'h3C);
    endfunction

    function automatic logic [7:0] ram_rd(int a);
        if (ram_m.exists(a)) return ram_m[a];
        return 8'(a ^ 8'hA5);
    endfunction

    // Expected target from the requirements (R3,R4,R5,R7,R9,R10).
    function automatic int exp_dev(logic [7:0] b, logic [15:0] a, logic r, bit sh);
        if (b == 8'h00 && a[15:8] == 8'h7F) return (a[7:0] == 8'h00) ? D_NONE : D_IO;
        if (sh && b == 8'h00 && a[15]) return r ? D_STORE : D_RAM;
        if (!sh && b == 8'hFF && a[15]) return D_STORE;
        return D_RAM;
    endfunction

    function automatic int seen_dev();
        int n;
        n = (!ram_cs_n) + (!store_cs_n) + (!io_cs_n);
        if (n > 1) return D_MULTI;
        if (!ram_cs_n) return D_RAM;
        if (!store_cs_n) return D_STORE;
        if (!io_cs_n) return D_IO;
        return D_NONE;
    endfunction

    // One processor bus cycle, repeated while rdy is low.
    task automatic bus(input logic [7:0] b, input logic [15:0] a, input logic r,
                       input logic [7:0] wd, output logic [7:0] rd, output int waits,
                       output int dev, output bit strobe_ok, output bit doe);
        bit done = 0;
        waits = 0;
        rd = 8'h00;
        strobe_ok = 1;
        doe = 0;
        while (!done) begin
            @(negedge phi2);
            #5;
            if (!(ram_cs_n && store_cs_n && io_cs_n)) low_phase_bad++;   // R11
            #5;
            addr = a; rw = r; data_in = b;
            @(posedge phi2);
            #10;
            data_in = r ? ~b : wd;      // R2: bus changes during high phase
            #30;
            dev = seen_dev();
            doe = data_oe;
            if (dev != D_NONE && dev != D_MULTI)
                strobe_ok = r ? (!oe_n && we_n) : (oe_n && !we_n);
            if (rdy) begin
                done = 1;
                if (r) begin
                    if (data_oe) rd = data_out;
                    else if (dev == D_STORE) rd = store_rd(int'(a[14:0]));
                    else if (dev == D_RAM) rd = ram_rd({b, a});
                    else if (dev == D_IO) rd = 8'h5A;
                end else begin
                    if (dev == D_STORE) store_m[int'(a[14:0])] = wd;
                    else if (dev == D_RAM) ram_m[{b, a}] = wd;
                end
            end else waits++;
        end
        if (!r && b == 8'h00 && a == 16'h7F00) model_shadow = 0;
    endtask

    task automatic rand_phase(int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b, rd, wd; logic [15:0] a; logic r;
            int w, d, ed, sel; bit sok, doe;
            sel = $urandom_range(0, 9);
            b = (sel < 4) ? 8'h00 : (sel < 8) ? 8'hFF : 8'($urandom);
            a = 16'($urandom);
            if (sel == 9) begin b = 8'h00; a = {8'h7F, 8'($urandom_range(1, 255))}; end
            if (b == 8'h00 && a == 16'h7F00) a = 16'h7F01;
            r = 1'($urandom);
            wd = 8'($urandom);
            ed = exp_dev(b, a, r, model_shadow);
            bus(b, a, r, wd, rd, w, d, sok, doe);
            check(ed == D_IO ? "R7" : ed == D_STORE ? (r ? "R4" : "R3") : "R10",
                  d == ed, "random target", d, ed);
            check("R6", w == ((ed == D_STORE) ? EXP_WAIT : 0), "random waits", w,
                  (ed == D_STORE) ? EXP_WAIT : 0);
            check("R3", sok, "strobe direction", sok, 1);
        end
    endtask

    initial begin
        logic [7:0] rd; int w, d; bit sok, doe;
        void'($urandom(32'h5EED_B007));

        // R1: nothing asserted while reset is held, even in the high phase
        @(posedge phi2); #30;
        check("R1", ram_cs_n && store_cs_n && io_cs_n && oe_n && we_n, "selects in reset",
              {ram_cs_n, store_cs_n, io_cs_n, oe_n, we_n}, 5'h1F);
        repeat (2) @(negedge phi2);
        #8 rst_n = 1'b1;

        // R1/R8: flag reads back as set
        bus(8'h00, 16'h7F00, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R8", doe && rd == 8'h80, "shadow flag after reset", rd, 8'h80);
        check("R7", d == D_NONE, "ctrl register selects nothing", d, D_NONE);

        // R10: top bank upper half is RAM during shadow mode
        bus(8'hFF, 16'h9000, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R10", d == D_RAM && w == 0, "top bank in shadow mode", d, D_RAM);

        rand_phase(150);

        // R4/R5: copy loop over a run of store bytes
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a; logic [7:0] v, st0;
            a = 16'h8000 + 16'(i * 37);
            st0 = store_rd(int'(a[14:0]));
            bus(8'h00, a, 1'b1, 8'h00, v, w, d, sok, doe);
            check("R4", d == D_STORE && v == st0, "overlay read from store", v, st0);
            check("R6", w == EXP_WAIT, "overlay read waits", w, EXP_WAIT);
            bus(8'h00, a, 1'b0, v, rd, w, d, sok, doe);
            check("R5", d == D_RAM && w == 0, "overlay write to RAM", d, D_RAM);
            check("R5", store_rd(int'(a[14:0])) == st0, "store untouched",
                  store_rd(int'(a[14:0])), st0);
        end

        // R7: I/O page other offset
        bus(8'h00, 16'h7F05, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R7", d == D_IO && !doe, "io page select", d, D_IO);

        // R7: exit, then flag reads zero (R8)
        bus(8'h00, 16'h7F00, 1'b0, 8'h00, rd, w, d, sok, doe);
        check("R7", d == D_NONE, "ctrl write selects nothing", d, D_NONE);
        bus(8'h00, 16'h7F00, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R8", doe && rd == 8'h00, "shadow flag after exit", rd, 8'h00);
        bus(8'h00, 16'h7F00, 1'b0, 8'hFF, rd, w, d, sok, doe);
        bus(8'h00, 16'h7F00, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R7", rd == 8'h00, "second write keeps mode off", rd, 8'h00);

        // R9/R2: copied bytes come from RAM at full speed
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a; logic [7:0] e;
            a = 16'h8000 + 16'(i * 37);
            e = store_rd(int'(a[14:0]));
            bus(8'h00, a, 1'b1, 8'h00, rd, w, d, sok, doe);
            check("R9", d == D_RAM && rd == e, "copied data from RAM", rd, e);
            check("R2", w == 0, "no wait after exit (bank held)", w, 0);
        end

        // R3: store writable in its home bank
        bus(8'hFF, 16'h8123, 1'b0, 8'h77, rd, w, d, sok, doe);
        check("R3", d == D_STORE && sok && w == EXP_WAIT, "home bank store write", d, D_STORE);
        bus(8'hFF, 16'h8123, 1'b1, 8'h00, rd, w, d, sok, doe);
        check("R3", rd == 8'h77, "home bank store readback", rd, 8'h77);

        rand_phase(150);

        check("R11", low_phase_bad == 0, "selects during low phase", low_phase_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule